// File: doc/BRIEF.md
# Aligned Contiguous Slot Allocator

This block manages a table of slots, each carrying a two-bit type tag that says whether the slot is unused, owned by a level-style source or owned by a message-style source. A client hands it one request at a time. An allocate request asks for a run of consecutive unused slots of a given length and, optionally, requires the run to start on a multiple of its length. A hinted request names one slot and claims it only if that slot is unused. A release request returns a run of slots to the unused state.

The allocator walks the table one slot per cycle. An allocate tries candidate starts from slot 0 upward, stepping by the run length when alignment is requested and by one otherwise. It gives up as soon as the current candidate would run past the end of the table. On success it tags every slot of the run and answers with the first slot number plus a fixed base offset. Malformed requests are answered with an error and leave the table alone. While a request is in progress the block reports busy and ignores new requests.

Control states: IDLE (waiting; a request is accepted here), SCAN (testing one slot of the current candidate per cycle), MARK (tagging the chosen run one slot per cycle), CLEAR (untagging a released run one slot per cycle) and RESP (one-cycle answer). Transitions: IDLE to RESP for an illegal request, IDLE to SCAN for a legal allocate or hinted request, IDLE to CLEAR for a legal release, SCAN to SCAN on a free slot or on a move to the next candidate, SCAN to MARK when the whole candidate is free, SCAN to RESP when no candidate fits or a hinted slot is taken, MARK to RESP and CLEAR to RESP after the last slot of the run, and RESP to IDLE.

Top module: `slot_alloc`

## Requirements
- R1: After reset every slot is unused (tag 0), busy is low and no answer is presented.
- R2: An allocate tries candidate starts 0, s, 2s and so on, where s is the count when the align bit is 1 and 1 when it is 0, and picks the lowest candidate whose slots are all unused.
- R3: An allocate answers fail (and changes no slot) when the first candidate whose start plus count exceeds the slot total is reached without a fit; a run that ends exactly at the last slot succeeds.
- R4: On success every slot of the run takes the requested tag (1 = level, 2 = message) and the answered index is the start slot plus BASE.
- R5: An allocate with count 0, with requested tag 0, or with the align bit set and a count that is not 1, 2, 4, 8, 16 or 32 answers error and changes no slot.
- R6: A hinted request (cmd 1) names the absolute index in req_index; it claims that slot alone with the requested tag when it is unused and answers fail, changing nothing, when it is in use.
- R7: A release (cmd 2) sets req_count slots starting at absolute index req_index back to unused, answers ok, and raises the warning bit on the answer when any of those slots was already unused.
- R8: Busy rises the cycle after a request is accepted and stays high until the answer cycle; the answer lasts one cycle with exactly one of ok, fail or error; a request raised while busy is ignored.
- R9: A hinted request or release whose range falls outside BASE to BASE plus the slot total minus 1, a release with count 0, and command code 3 all answer error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_cmd | input | 2 | 0 allocate, 1 hinted single slot, 2 release, 3 reserved |
| req_count | input | CNT_W | Run length |
| req_align | input | 1 | Run start must be a multiple of the count |
| req_type | input | 2 | Tag to write: 1 level, 2 message |
| req_index | input | OUT_W | Absolute index for hinted and release requests |
| busy | output | 1 | A request is being processed |
| rsp_done | output | 1 | One-cycle answer strobe |
| rsp_ok | output | 1 | Request completed |
| rsp_fail | output | 1 | No room, or hinted slot in use |
| rsp_err | output | 1 | Request malformed |
| rsp_warn | output | 1 | Release touched an unused slot |
| rsp_index | output | OUT_W | First slot of the run plus BASE |

## Verification
Two events can share a cycle: the answer of one request and the arrival of the next, and a new request raised while a long scan is still running. The bench waits for busy to fall before each request, so the answer cycle and the next acceptance lie next to each other, and it also raises a release request in the middle of a long allocation. The scoreboard fails on any answer it did not expect, and a later hinted claim of a slot that the ignored release would have freed shows that the table kept its contents.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic [1:0] {
        TAG_FREE  = 2'd0,
        TAG_LEVEL = 2'd1,
        TAG_MSG   = 2'd2
    } tag_e;

    typedef enum logic [1:0] {
        CMD_ALLOC = 2'd0,
        CMD_HINT  = 2'd1,
        CMD_FREE  = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MARK,
        ST_CLEAR,
        ST_RESP
    } state_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_FAIL = 2'd1,
        RES_ERR  = 2'd2
    } res_e;

endpackage

// File: rtl/slot_table.sv
module slot_table
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] addr,
    input  logic             wr_en,
    input  tag_e             wr_tag,
    output tag_e             rd_tag
);

    tag_e tags [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                tags[i] <= TAG_FREE;
            end
        end else if (wr_en) begin
            tags[addr] <= wr_tag;
        end
    end

    assign rd_tag = tags[addr];

    // a claim may only land on an unused slot
    AST_CLAIM_ONLY_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tag != TAG_FREE) |-> (tags[addr] == TAG_FREE)); // R4

endmodule

// File: rtl/slot_req_check.sv
module slot_req_check
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int BASE      = 4096,
    parameter int OUT_W     = 16,
    parameter int MAX_ALIGN = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic [1:0]       cmd,
    input  logic [CNT_W-1:0] count,
    input  logic             align,
    input  logic [1:0]       type_i,
    input  logic [OUT_W-1:0] index,
    output logic             legal,
    output logic [IDX_W-1:0] first,
    output logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] step
);

    logic [31:0] rel;
    logic        in_range;
    logic        pow2_ok;
    logic        nonzero;
    logic        type_ok;

    always_comb begin
        rel      = 32'(index) - 32'(BASE);
        in_range = (32'(index) >= 32'(BASE)) && (rel < 32'(NUM_SLOTS));
        nonzero  = (count != '0);
        pow2_ok  = nonzero && ((count & (count - CNT_W'(1))) == '0)
                   && (32'(count) <= 32'(MAX_ALIGN));
        type_ok  = (type_i == TAG_LEVEL) || (type_i == TAG_MSG);

        legal = 1'b0;
        first = '0;
        len   = count;
        step  = CNT_W'(1);
        unique case (cmd)
            CMD_ALLOC: begin
                legal = nonzero && type_ok && (!align || pow2_ok);
                step  = align ? count : CNT_W'(1);
            end
            CMD_HINT: begin
                legal = in_range && type_ok;
                first = rel[IDX_W-1:0];
                len   = CNT_W'(1);
            end
            CMD_FREE: begin
                legal = nonzero && in_range
                        && ((rel + 32'(count)) <= 32'(NUM_SLOTS));
                first = rel[IDX_W-1:0];
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/slot_alloc_ctrl.sv
module slot_alloc_ctrl
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int BASE      = 4096,
    parameter int OUT_W     = 16,
    parameter int IDX_W     = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1),
    parameter int POS_W     = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_cmd,
    input  logic             req_align,
    input  logic [1:0]       req_type,
    input  logic             legal,
    input  logic [IDX_W-1:0] first,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] step,
    output logic [IDX_W-1:0] tbl_addr,
    output logic             tbl_wr_en,
    output tag_e             tbl_wr_tag,
    input  tag_e             tbl_rd_tag,
    output logic             busy,
    output logic             rsp_done,
    output logic             rsp_ok,
    output logic             rsp_fail,
    output logic             rsp_err,
    output logic             rsp_warn,
    output logic [OUT_W-1:0] rsp_index
);

    state_e           state_q, state_d;
    cmd_e             cmd_q;
    tag_e             type_q;
    res_e             res_q;
    logic             align_q;
    logic             warn_q;
    logic [POS_W-1:0] start_q;
    logic [CNT_W-1:0] off_q, len_q, step_q;
    logic [POS_W-1:0] slot_pos;
    logic             fits, last, slot_free, accept;

    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE);
        slot_pos  = start_q + POS_W'(off_q);
        fits      = (start_q + POS_W'(len_q)) <= POS_W'(NUM_SLOTS);
        last      = (off_q == len_q - CNT_W'(1));
        slot_free = (tbl_rd_tag == TAG_FREE);
        tbl_addr  = slot_pos[IDX_W-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (!legal)                  state_d = ST_RESP;
                else if (req_cmd == CMD_FREE) state_d = ST_CLEAR;
                else                         state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (!fits)                      state_d = ST_RESP;
                else if (!slot_free && cmd_q == CMD_HINT) state_d = ST_RESP;
                else if (slot_free && last)     state_d = ST_MARK;
            end
            ST_MARK:  if (last) state_d = ST_RESP;
            ST_CLEAR: if (last) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_ALLOC;
            type_q  <= TAG_FREE;
            res_q   <= RES_OK;
            align_q <= 1'b0;
            warn_q  <= 1'b0;
            start_q <= '0;
            off_q   <= '0;
            len_q   <= '0;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    cmd_q   <= cmd_e'(req_cmd);
                    type_q  <= tag_e'(req_type);
                    align_q <= req_align;
                    res_q   <= legal ? RES_OK : RES_ERR;
                    warn_q  <= 1'b0;
                    start_q <= POS_W'(first);
                    off_q   <= '0;
                    len_q   <= len;
                    step_q  <= step;
                end
                ST_SCAN: begin
                    if (!fits) begin
                        res_q <= RES_FAIL;
                    end else if (!slot_free) begin
                        if (cmd_q == CMD_HINT) res_q <= RES_FAIL;
                        start_q <= start_q + POS_W'(step_q);
                        off_q   <= '0;
                    end else begin
                        off_q <= last ? '0 : off_q + CNT_W'(1);
                    end
                end
                ST_MARK: off_q <= off_q + CNT_W'(1);
                ST_CLEAR: begin
                    warn_q <= warn_q | slot_free;
                    off_q  <= off_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        rsp_done   = (state_q == ST_RESP);
        rsp_ok     = rsp_done && (res_q == RES_OK);
        rsp_fail   = rsp_done && (res_q == RES_FAIL);
        rsp_err    = rsp_done && (res_q == RES_ERR);
        rsp_warn   = rsp_done && warn_q;
        rsp_index  = OUT_W'(BASE) + OUT_W'(start_q);
        tbl_wr_en  = (state_q == ST_MARK) || (state_q == ST_CLEAR);
        tbl_wr_tag = (state_q == ST_MARK) ? type_q : TAG_FREE;
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($countones({rsp_ok, rsp_fail, rsp_err}) == 1)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R8
    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok && cmd_q == CMD_ALLOC && align_q)
        |-> ((start_q % POS_W'(step_q)) == '0)); // R2
    AST_WARN_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_warn |-> (cmd_q == CMD_FREE)); // R7

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int BASE      = 4096,
    parameter int OUT_W     = 16,
    parameter int MAX_ALIGN = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_cmd,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_align,
    input  logic [1:0]       req_type,
    input  logic [OUT_W-1:0] req_index,
    output logic             busy,
    output logic             rsp_done,
    output logic             rsp_ok,
    output logic             rsp_fail,
    output logic             rsp_err,
    output logic             rsp_warn,
    output logic [OUT_W-1:0] rsp_index
);

    logic             legal;
    logic [IDX_W-1:0] first;
    logic [CNT_W-1:0] len, step;
    logic [IDX_W-1:0] tbl_addr;
    logic             tbl_wr_en;
    tag_e             tbl_wr_tag, tbl_rd_tag;

    slot_req_check #(
        .NUM_SLOTS(NUM_SLOTS), .BASE(BASE), .OUT_W(OUT_W),
        .MAX_ALIGN(MAX_ALIGN), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_check (
        .cmd(req_cmd), .count(req_count), .align(req_align),
        .type_i(req_type), .index(req_index),
        .legal(legal), .first(first), .len(len), .step(step)
    );

    slot_alloc_ctrl #(
        .NUM_SLOTS(NUM_SLOTS), .BASE(BASE), .OUT_W(OUT_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cmd(req_cmd),
        .req_align(req_align), .req_type(req_type),
        .legal(legal), .first(first), .len(len), .step(step),
        .tbl_addr(tbl_addr), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_tag(tbl_wr_tag), .tbl_rd_tag(tbl_rd_tag),
        .busy(busy), .rsp_done(rsp_done), .rsp_ok(rsp_ok),
        .rsp_fail(rsp_fail), .rsp_err(rsp_err), .rsp_warn(rsp_warn),
        .rsp_index(rsp_index)
    );

    slot_table #(
        .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .addr(tbl_addr),
        .wr_en(tbl_wr_en), .wr_tag(tbl_wr_tag), .rd_tag(tbl_rd_tag)
    );

endmodule

// File: tb/slot_alloc_bench.sv
module slot_alloc_bench;

    localparam int N     = 32;
    localparam int BASE  = 4096;
    localparam int OUT_W = 16;
    localparam int CNT_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_cmd = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             req_align = 1'b0;
    logic [1:0]       req_type = '0;
    logic [OUT_W-1:0] req_index = '0;
    logic             busy, rsp_done, rsp_ok, rsp_fail, rsp_err, rsp_warn;
    logic [OUT_W-1:0] rsp_index;

    slot_alloc #(.NUM_SLOTS(N), .BASE(BASE), .OUT_W(OUT_W)) u_slot_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_count(req_count), .req_align(req_align), .req_type(req_type),
        .req_index(req_index), .busy(busy), .rsp_done(rsp_done),
        .rsp_ok(rsp_ok), .rsp_fail(rsp_fail), .rsp_err(rsp_err),
        .rsp_warn(rsp_warn), .rsp_index(rsp_index)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    res;      // 0 ok, 1 fail, 2 error
        int    idx;
        bit    warn;
        bit    chk_idx;
        string lbl;
    } exp_t;

    exp_t q[$];
    int   tb_tag[N];
    int   n_chk = 0;
    int   n_fail = 0;

    task automatic check(input bit cond, input string lbl, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", lbl, what, act, expv);
        end
    endtask

    function automatic bit pow2_le32(input int c);
        return (c == 1 || c == 2 || c == 4 || c == 8 || c == 16 || c == 32);
    endfunction

    // reference model of the requirements; updates tb_tag
    task automatic predict(input int c, input int cnt, input bit al, input int ty,
                           input int ix, input string lbl);
        exp_t e;
        int   rel;
        e.res = 2; e.idx = 0; e.warn = 0; e.chk_idx = 0; e.lbl = lbl;
        rel = ix - BASE;
        if (c == 0) begin
            if (cnt != 0 && (ty == 1 || ty == 2) && (!al || pow2_le32(cnt))) begin
                int st;
                int stp;
                e.res = 1;
                stp = al ? cnt : 1;
                st = 0;
                while (st + cnt <= N && e.res == 1) begin
                    bit ok = 1;
                    for (int k = 0; k < cnt; k++) if (tb_tag[st + k] != 0) ok = 0;
                    if (ok) begin
                        e.res = 0; e.idx = st + BASE; e.chk_idx = 1;
                        for (int k = 0; k < cnt; k++) tb_tag[st + k] = ty;
                    end else begin
                        st += stp;
                    end
                end
            end
        end else if (c == 1) begin
            if (ix >= BASE && rel < N && (ty == 1 || ty == 2)) begin
                if (tb_tag[rel] == 0) begin
                    e.res = 0; e.idx = ix; e.chk_idx = 1; tb_tag[rel] = ty;
                end else begin
                    e.res = 1;
                end
            end
        end else if (c == 2) begin
            if (cnt != 0 && ix >= BASE && rel < N && rel + cnt <= N) begin
                e.res = 0;
                for (int k = 0; k < cnt; k++) begin
                    if (tb_tag[rel + k] == 0) e.warn = 1;
                    tb_tag[rel + k] = 0;
                end
            end
        end
        q.push_back(e);
    endtask

    task automatic drive(input int c, input int cnt, input bit al, input int ty,
                         input int ix);
        req_cmd   = 2'(c);
        req_count = CNT_W'(cnt);
        req_align = al;
        req_type  = 2'(ty);
        req_index = OUT_W'(ix);
        req_valid = 1'b1;
    endtask

    task automatic do_req(input int c, input int cnt, input bit al, input int ty,
                          input int ix, input string lbl);
        @(negedge clk);
        while (busy) @(negedge clk);
        predict(c, cnt, al, ty, ix, lbl);
        drive(c, cnt, al, ty, ix);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
    endtask

    // monitor: compares each answer with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected answer", 1, 0);
            end else begin
                exp_t e;
                int   act;
                e = q.pop_front();
                act = rsp_ok ? 0 : (rsp_fail ? 1 : (rsp_err ? 2 : 3));
                check(act == e.res, e.lbl, "result", act, e.res);
                check(rsp_warn == e.warn, e.lbl, "warn", int'(rsp_warn), int'(e.warn));
                if (e.chk_idx)
                    check(int'(rsp_index) == e.idx, e.lbl, "index", int'(rsp_index), e.idx);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) tb_tag[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(rsp_done == 1'b0, "R1", "done after reset", int'(rsp_done), 0);

        // R1: empty table takes a full-length run; R7 clean release
        do_req(0, 32, 0, 1, 0, "R1 full run");
        do_req(2, 32, 0, 0, BASE, "R7 release all");

        // R4 / R2 first fit and alignment steps
        do_req(0, 3, 0, 1, 0, "R4 level run");
        do_req(0, 2, 1, 2, 0, "R2 aligned pair");
        do_req(0, 1, 0, 2, 0, "R2 gap fill");

        // R6 hinted claims
        do_req(1, 1, 0, 1, BASE + 10, "R6 hint free");
        do_req(1, 1, 0, 2, BASE + 10, "R6 hint taken");
        do_req(1, 1, 0, 1, BASE + 3, "R6 hint used");

        // R5 malformed allocations
        do_req(0, 3, 1, 1, 0, "R5 odd aligned");
        do_req(0, 0, 0, 1, 0, "R5 zero count");
        do_req(0, 2, 0, 0, 0, "R5 unused tag");

        // R3 no fit and exact fit at the end
        do_req(0, 32, 1, 1, 0, "R3 aligned 32");
        do_req(0, 22, 0, 2, 0, "R3 too long");
        do_req(0, 21, 0, 2, 0, "R3 exact end");
        do_req(2, 21, 0, 0, BASE + 11, "R7 release tail");

        // R7 release over partly unused range, then reuse
        do_req(2, 4, 0, 0, BASE + 4, "R7 warn release");
        do_req(0, 4, 1, 1, 0, "R7 reuse aligned");

        // R9 range and command errors
        do_req(1, 1, 0, 1, BASE - 1, "R9 hint below");
        do_req(2, 4, 0, 0, BASE + 30, "R9 release past end");
        do_req(2, 0, 0, 0, BASE, "R9 release zero");
        do_req(3, 1, 0, 1, BASE, "R9 reserved cmd");

        // R8 request during a long scan is ignored
        do_req(0, 20, 0, 2, 0, "R8 long scan");
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R8", "busy during scan", int'(busy), 1);
        drive(2, 32, 0, 0, BASE);
        @(negedge clk);
        req_valid = 1'b0;
        do_req(1, 1, 0, 1, BASE, "R8 table kept");

        @(negedge clk);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule